// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block produces one pulse-width-modulated output whose period is set by an 8-bit period value and whose high time is set by a 10-bit duty value. An 8-bit timer advances once every four system clocks times a selectable prescale of 1, 4 or 16. Two fine bits are appended below the timer to give 10 bits of duty resolution. At prescale 1 the fine bits are a free-running divide-by-4 phase counter. At the larger prescales they are bits of the prescale counter. The extended count therefore advances once every `prescale` system clocks.

Software may write the duty value at any moment. The written value sits in a holding register. It is copied into the active compare register only when the timer reaches the period value and wraps. At that same instant the output is set high (unless the new duty is zero) and a one-cycle period strobe is raised. The output falls when the extended count reaches the active duty. If the duty is larger than the period allows, the output stays high for the whole period.

A 2-bit output-mode field is kept for compatibility with multi-output configurations. Only the single-output code drives the pin. All configuration inputs are plain write strobes with data, sampled on the rising clock edge. No stream traffic passes through the block, so it has no valid/ready interface and never applies back-pressure.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `pwm_o` and `match_o` are both 0. Registers reset to period 0xFF, prescale 1, single mode and duty 0.
- R2: One PWM period lasts (period + 1) × 4 × prescale system clocks. The prescale code is 00 = 1, 01 = 4, 10 = 16 and 11 = 16.
- R3: `match_o` is high for exactly one cycle per period, in the first cycle of the new period. In single mode, `pwm_o` rises only in a cycle where `match_o` is high.
- R4: With committed duty D = {msb byte, lsb pair} where 0 < D × prescale < period length, `pwm_o` is high for exactly D × prescale system clocks at the start of each period.
- R5: A duty write during a period leaves the high time of that period unchanged. The new value governs the next period.
- R6: When D × prescale is greater than or equal to the period length, `pwm_o` stays high for the entire period.
- R7: When the committed duty is zero, `pwm_o` stays low for the entire period.
- R8: The mode field uses code 00 = single, 01 = half-bridge, 10 = full-bridge forward and 11 = full-bridge reverse. Only code 00 drives `pwm_o`. Any other code holds `pwm_o` at 0, while the timer and `match_o` keep running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_we | input | 1 | Write strobe for the period value |
| per_wdata | input | 8 | Period value (timer terminal count) |
| dmsb_we | input | 1 | Write strobe for the duty upper byte |
| dmsb_wdata | input | 8 | Duty bits 9..2 |
| dlsb_we | input | 1 | Write strobe for the duty lower pair |
| dlsb_wdata | input | 2 | Duty bits 1..0 |
| psc_we | input | 1 | Write strobe for the prescale code |
| psc_wdata | input | 2 | Prescale code (00 = 1, 01 = 4, 1x = 16) |
| omode_we | input | 1 | Write strobe for the output-mode code |
| omode_wdata | input | 2 | Output-mode code (00 = single) |
| pwm_o | output | 1 | PWM output |
| match_o | output | 1 | One-cycle strobe at each period restart |

## Verification
The assertions assume that the period value is never lowered below the current timer count. If it were, the timer would run through its full 8-bit range before it restarts. They also assume that a rise of the output with no strobe can only come from a change of the mode code, which is why that property excludes cycles where the mode changed. The stimulus writes period, prescale and duty together in the cycle just after a period strobe, while the timer is still at zero. It then lets one full period pass before measuring, so every measured period runs under settled settings. Mid-period duty writes are placed at random offsets that stay clear of the next restart edge.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;

  // Prescale selector: the extended count advances every 1, 4 or 16 clocks
  typedef enum logic [1:0] {
    PSC_DIV1   = 2'b00,
    PSC_DIV4   = 2'b01,
    PSC_DIV16  = 2'b10,
    PSC_DIV16B = 2'b11
  } psc_sel_e;

  // Output configuration code; only OM_SINGLE drives the pin here
  typedef enum logic [1:0] {
    OM_SINGLE   = 2'b00,
    OM_HALF     = 2'b01,
    OM_FULL_FWD = 2'b10,
    OM_FULL_REV = 2'b11
  } out_mode_e;

endpackage

// File: rtl/pwm_ctrl_regs.sv
`timescale 1ns/1ps
module pwm_ctrl_regs
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    per_we,
  input  logic [TMR_W-1:0]        per_wdata,
  input  logic                    dmsb_we,
  input  logic [TMR_W-1:0]        dmsb_wdata,
  input  logic                    dlsb_we,
  input  logic [FINE_W-1:0]       dlsb_wdata,
  input  logic                    psc_we,
  input  logic [1:0]              psc_wdata,
  input  logic                    omode_we,
  input  logic [1:0]              omode_wdata,
  input  logic                    commit,
  output logic [TMR_W-1:0]        period_q,
  output psc_sel_e                psc_q,
  output out_mode_e               mode_q,
  output logic [TMR_W+FINE_W-1:0] duty_buf,
  output logic [TMR_W+FINE_W-1:0] duty_act
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  dmsb_q;
  logic [FINE_W-1:0] dlsb_q;

  // Software-visible holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      psc_q    <= PSC_DIV1;
      mode_q   <= OM_SINGLE;
      dmsb_q   <= '0;
      dlsb_q   <= '0;
    end else begin
      if (per_we)   period_q <= per_wdata;
      if (psc_we)   psc_q    <= psc_sel_e'(psc_wdata);
      if (omode_we) mode_q   <= out_mode_e'(omode_wdata);
      if (dmsb_we)  dmsb_q   <= dmsb_wdata;
      if (dlsb_we)  dlsb_q   <= dlsb_wdata;
    end
  end

  assign duty_buf = {dmsb_q, dlsb_q};

  // Active (shadow) duty: loaded only at period restart, never by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
    end else if (commit) begin
      duty_act <= duty_buf;
    end
  end

  logic [DUTY_W-1:0] unused_chk;
  assign unused_chk = duty_act;

endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  period,
  input  psc_sel_e          psc_sel,
  output logic [TMR_W-1:0]  tmr_nxt,
  output logic [FINE_W-1:0] fine_nxt,
  output logic              restart
);

  localparam int PSC_W = 2 * FINE_W;

  logic [FINE_W-1:0] ph_q, ph_nxt;
  logic [PSC_W-1:0]  pc_q, pc_nxt;
  logic [TMR_W-1:0]  tmr_q;
  logic              ph_wrap;
  logic              tick;

  // Picks the fine bits for the current prescale setting
  function automatic logic [FINE_W-1:0] fine_of(
    input psc_sel_e          sel,
    input logic [FINE_W-1:0] ph,
    input logic [PSC_W-1:0]  pc
  );
    case (sel)
      PSC_DIV1: fine_of = ph;
      PSC_DIV4: fine_of = pc[FINE_W-1:0];
      default:  fine_of = pc[PSC_W-1:FINE_W];
    endcase
  endfunction

  assign ph_wrap = &ph_q;
  assign ph_nxt  = ph_q + 1'b1;
  assign pc_nxt  = ph_wrap ? pc_q + 1'b1 : pc_q;

  always_comb begin
    case (psc_sel)
      PSC_DIV1: tick = ph_wrap;
      PSC_DIV4: tick = ph_wrap & (&pc_q[FINE_W-1:0]);
      default:  tick = ph_wrap & (&pc_q);
    endcase
  end

  assign restart  = tick && (tmr_q == period);
  assign tmr_nxt  = restart ? '0 : (tick ? tmr_q + 1'b1 : tmr_q);
  assign fine_nxt = fine_of(psc_sel, ph_nxt, pc_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      pc_q  <= '0;
      tmr_q <= '0;
    end else begin
      ph_q  <= ph_nxt;
      pc_q  <= pc_nxt;
      tmr_q <= tmr_nxt;
    end
  end

endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [DUTY_W-1:0] cnt_nxt,
  input  logic [DUTY_W-1:0] duty_act,
  input  logic [DUTY_W-1:0] duty_buf,
  input  out_mode_e         mode,
  output logic              pwm_o,
  output logic              match_o
);

  logic pwm_q;

  // Set at restart (unless the incoming duty is zero), clear on compare.
  // The compare uses the count value about to be loaded so the fall
  // lands on the same edge as the count reaching the duty.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b0;
      match_o <= 1'b0;
    end else begin
      match_o <= restart;
      if (restart) begin
        pwm_q <= (duty_buf != '0);
      end else if (cnt_nxt == duty_act) begin
        pwm_q <= 1'b0;
      end
    end
  end

  assign pwm_o = (mode == OM_SINGLE) ? pwm_q : 1'b0;

endmodule

// File: rtl/pwm_dbuf_gen.sv
`timescale 1ns/1ps
module pwm_dbuf_gen
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_we,
  input  logic [TMR_W-1:0]  per_wdata,
  input  logic              dmsb_we,
  input  logic [TMR_W-1:0]  dmsb_wdata,
  input  logic              dlsb_we,
  input  logic [FINE_W-1:0] dlsb_wdata,
  input  logic              psc_we,
  input  logic [1:0]        psc_wdata,
  input  logic              omode_we,
  input  logic [1:0]        omode_wdata,
  output logic              pwm_o,
  output logic              match_o
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  period_q;
  psc_sel_e          psc_q;
  out_mode_e         mode_q;
  logic [DUTY_W-1:0] duty_buf;
  logic [DUTY_W-1:0] duty_act;
  logic [TMR_W-1:0]  tmr_nxt;
  logic [FINE_W-1:0] fine_nxt;
  logic              restart;

  pwm_ctrl_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .per_we      (per_we),
    .per_wdata   (per_wdata),
    .dmsb_we     (dmsb_we),
    .dmsb_wdata  (dmsb_wdata),
    .dlsb_we     (dlsb_we),
    .dlsb_wdata  (dlsb_wdata),
    .psc_we      (psc_we),
    .psc_wdata   (psc_wdata),
    .omode_we    (omode_we),
    .omode_wdata (omode_wdata),
    .commit      (restart),
    .period_q    (period_q),
    .psc_q       (psc_q),
    .mode_q      (mode_q),
    .duty_buf    (duty_buf),
    .duty_act    (duty_act)
  );

  pwm_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) tb_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .period   (period_q),
    .psc_sel  (psc_q),
    .tmr_nxt  (tmr_nxt),
    .fine_nxt (fine_nxt),
    .restart  (restart)
  );

  pwm_out_stage #(.DUTY_W(DUTY_W)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .cnt_nxt  ({tmr_nxt, fine_nxt}),
    .duty_act (duty_act),
    .duty_buf (duty_buf),
    .mode     (mode_q),
    .pwm_o    (pwm_o),
    .match_o  (match_o)
  );

endmodule

// File: rtl/pwm_dbuf_gen_chk.sv
`timescale 1ns/1ps
module pwm_dbuf_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_o,
  input logic       match_o,
  input logic [1:0] mode_q
);

  logic [3:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (match_o)      gap_q <= '0;
      else if (~&gap_q) gap_q <= gap_q + 1'b1;
      if (match_o)      seen_q <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pwm_o && !match_o)); // R1

  AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o); // R3

  AST_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_o) && $stable(mode_q)) |-> match_o); // R3

  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && seen_q) |-> (gap_q >= 4'd3)); // R2

  AST_MODE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00) |-> !pwm_o); // R8

endmodule

bind pwm_dbuf_gen pwm_dbuf_gen_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_o   (pwm_o),
  .match_o (match_o),
  .mode_q  (mode_q)
);

// File: tb/pwm_dbuf_gen_tb.sv
`timescale 1ns/1ps
module pwm_dbuf_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_we = 1'b0;
  logic [7:0] per_wdata = '0;
  logic       dmsb_we = 1'b0;
  logic [7:0] dmsb_wdata = '0;
  logic       dlsb_we = 1'b0;
  logic [1:0] dlsb_wdata = '0;
  logic       psc_we = 1'b0;
  logic [1:0] psc_wdata = '0;
  logic       omode_we = 1'b0;
  logic [1:0] omode_wdata = '0;
  logic       pwm_o;
  logic       match_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dbuf_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .per_we(per_we), .per_wdata(per_wdata),
    .dmsb_we(dmsb_we), .dmsb_wdata(dmsb_wdata),
    .dlsb_we(dlsb_we), .dlsb_wdata(dlsb_wdata),
    .psc_we(psc_we), .psc_wdata(psc_wdata),
    .omode_we(omode_we), .omode_wdata(omode_wdata),
    .pwm_o(pwm_o), .match_o(match_o)
  );

  function automatic int pscale(input int code);
    return (code == 0) ? 1 : ((code == 1) ? 4 : 16);
  endfunction

  function automatic int exp_len(input int pr, input int code);
    return (pr + 1) * 4 * pscale(code);
  endfunction

  function automatic int exp_high(input int d, input int pr, input int code);
    int len;
    len = exp_len(pr, code);
    if (d == 0) return 0;
    if (d * pscale(code) >= len) return len;
    return d * pscale(code);
  endfunction

  function automatic string cls(input int d, input int pr, input int code);
    if (d == 0) return "R7";
    if (d * pscale(code) >= exp_len(pr, code)) return "R6";
    return "R4";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_match();
    do @(negedge clk); while (!match_o);
  endtask

  // Starts on a sample where match_o is high, stops on the next one
  task automatic measure(output int len, output int hi, output int first_pwm, output int second_match);
    len = 0; hi = 0; first_pwm = int'(pwm_o); second_match = 0;
    do begin
      len++;
      if (pwm_o) hi++;
      @(negedge clk);
      if (len == 1) second_match = int'(match_o);
    end while (!match_o);
  endtask

  task automatic cfg(input int pr, input int code, input int d);
    per_we = 1'b1; per_wdata = pr[7:0];
    psc_we = 1'b1; psc_wdata = code[1:0];
    dmsb_we = 1'b1; dmsb_wdata = d[9:2];
    dlsb_we = 1'b1; dlsb_wdata = d[1:0];
    @(negedge clk);
    per_we = 1'b0; psc_we = 1'b0; dmsb_we = 1'b0; dlsb_we = 1'b0;
  endtask

  task automatic wr_duty(input int d);
    dmsb_we = 1'b1; dmsb_wdata = d[9:2];
    dlsb_we = 1'b1; dlsb_wdata = d[1:0];
    @(negedge clk);
    dmsb_we = 1'b0; dlsb_we = 1'b0;
  endtask

  task automatic wr_mode(input int m);
    omode_we = 1'b1; omode_wdata = m[1:0];
    @(negedge clk);
    omode_we = 1'b0;
  endtask

  // Period A uses d1; d2 is written mid-A and must show up only in period B
  task automatic trial(input int pr, input int code, input int d1, input int d2, input int off_sel);
    int lenA, hiA, fpA, smA, lenB, hiB, fpB, smB, len, off;
    len = exp_len(pr, code);
    off = 1 + (off_sel % (len - 2));
    wait_match();
    cfg(pr, code, d1);
    wait_match();
    wait_match();
    fork
      measure(lenA, hiA, fpA, smA);
      begin
        repeat (off) @(negedge clk);
        wr_duty(d2);
      end
    join
    measure(lenB, hiB, fpB, smB);
    check("R2", $sformatf("period len pr=%0d psc=%0d", pr, code), lenA, len);
    check({"R5/", cls(d1, pr, code)}, $sformatf("high A d=%0d pr=%0d psc=%0d", d1, pr, code), hiA, exp_high(d1, pr, code));
    check("R3", "output high with strobe in A", fpA, (d1 != 0) ? 1 : 0);
    check("R3", "strobe lasts one cycle", smA, 0);
    check("R2", "period len B", lenB, len);
    check({"R5/", cls(d2, pr, code)}, $sformatf("high B d=%0d pr=%0d psc=%0d", d2, pr, code), hiB, exp_high(d2, pr, code));
  endtask

  initial begin
    int seed_dummy;
    int len, hi, fp, sm;
    seed_dummy = $urandom(32'd20240607);
    repeat (4) @(negedge clk);
    check("R1", "pwm_o in reset", int'(pwm_o), 0);
    check("R1", "match_o in reset", int'(match_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pwm_o after reset", int'(pwm_o), 0);
    check("R1", "match_o after reset", int'(match_o), 0);

    // Reset period 0xFF, prescale 1: first period is 1024 clocks, output low (R1, R2, R7)
    wait_match();
    measure(len, hi, fp, sm);
    check("R2", "reset-default period", len, 1024);
    check("R7", "reset-default duty zero", hi, 0);

    // Directed corner cases
    trial(3, 0, 5, 1023, 3);     // above-period duty (R6)
    trial(3, 0, 16, 0, 5);       // exactly full, then zero (R6, R7)
    trial(3, 0, 1, 15, 7);       // smallest non-zero duty
    trial(1, 1, 3, 7, 11);       // prescale 4
    trial(2, 2, 6, 11, 20);      // prescale 16
    trial(1, 3, 2, 0, 9);        // code 11 also 16
    trial(0, 0, 2, 3, 1);        // shortest period
    trial(255, 0, 512, 1, 400);  // 10-bit resolution at prescale 1
    trial(63, 1, 100, 255, 300); // prescale 4

    // Mode field: non-single codes hold the pin low, strobe continues (R8)
    for (int m = 1; m < 4; m++) begin
      wait_match();
      cfg(3, 0, 8);
      wr_mode(m);
      wait_match();
      measure(len, hi, fp, sm);
      check("R8", $sformatf("pin held low mode=%0d", m), hi, 0);
      check("R8", $sformatf("strobe period mode=%0d", m), len, 16);
      wr_mode(0);
    end
    wait_match();
    wait_match();
    measure(len, hi, fp, sm);
    check("R8", "single mode restored", hi, 8);

    // Constrained random trials
    for (int i = 0; i < 20; i++) begin
      int pr, code, d1, d2;
      pr   = $urandom_range(0, 10);
      code = $urandom_range(0, 3);
      d1   = $urandom_range(0, (pr + 1) * 4 + 6);
      d2   = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(0, (pr + 1) * 4 + 6);
      trial(pr, code, d1, d2, $urandom_range(0, 1000));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule